// File: doc/BRIEF.md
# SPI Channel Word Buffer with Request Thresholds

This block sits between a host and the shift engine of one SPI channel. On the transmit side the host writes words and the shift engine takes them. On the receive side the shift engine delivers words and the host reads them. Each side has its own enable that picks between a multi-word queue and a single holding register. The block reports empty and full for each side and raises a level request for each side. The transmit request means the queue has drained to a programmable low mark. The receive request means the queue has filled to a programmable high mark.

A programmable transfer length counts the words the shift engine reports as finished. When the set number is reached, the block raises an end-of-words event and starts counting again. A length of zero turns the counter off. Transmit underflow and receive overflow are also detected. Every event is held in a sticky status vector that is cleared by writing one, and it drives a single interrupt line through an enable mask. The serial shifting, DMA and bus decoding are outside this block. Its configuration arrives on plain input pins.

Top module: `spi_word_buf`

## Requirements
- R1: After reset both sides are empty and not full, `irq_status` is all zero and `irq_out` is low.
- R2: Words leave each side in the order they entered. The oldest transmit word is shown on `eng_tx_data` and the oldest receive word on `host_rd_data`. An accepted take moves to the next word on the following clock edge.
- R3: With its enable high, a side holds DEPTH words (8 by default) and reports full at that point. With its enable low, it holds one word and reports full after a single write.
- R4: A write to a full transmit side and a read from an empty receive side are ignored. Stored contents and the order of the stored words stay unchanged.
- R5: `tx_level_req` is high exactly when the number of words held on the transmit side is less than or equal to `tx_low_mark`.
- R6: `rx_level_req` is high exactly when the number of words held on the receive side is greater than or equal to `rx_high_mark`.
- R7: When `xfer_words` is nonzero, `irq_status` bit 4 sets after the `xfer_words`-th `eng_word_done` pulse. The count then restarts from zero.
- R8: When `xfer_words` is zero, no end-of-words event is produced, however many words finish.
- R9: `eng_tx_req` while the transmit side is empty sets `irq_status` bit 1 (transmit underflow).
- R10: `eng_rx_push` while the receive side is full drops the word. It sets `irq_status` bit 3 (receive overflow) only when `slave_mode` is high.
- R11: Status bits are sticky. A one on `irq_clear` clears the matching bit, but an event in the same cycle keeps the bit set. Bit 0 follows the transmit request and bit 2 the receive request. `irq_out` is high when any status bit with its `irq_enable` bit set is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_queue_on | input | 1 | Transmit side buffering enable (0 = one word) |
| rx_queue_on | input | 1 | Receive side buffering enable (0 = one word) |
| slave_mode | input | 1 | Channel runs as slave; enables overflow detection |
| tx_low_mark | input | 8 | Transmit almost-empty level |
| rx_high_mark | input | 8 | Receive almost-full level |
| xfer_words | input | 16 | Words per transfer; 0 disables the counter |
| host_wr_en | input | 1 | Host writes a transmit word |
| host_wr_data | input | DW | Transmit word from host |
| host_rd_en | input | 1 | Host takes the oldest receive word |
| host_rd_data | output | DW | Oldest receive word |
| eng_tx_req | input | 1 | Shift engine takes the oldest transmit word |
| eng_tx_data | output | DW | Oldest transmit word |
| eng_rx_push | input | 1 | Shift engine delivers a received word |
| eng_rx_data | input | DW | Received word |
| eng_word_done | input | 1 | Shift engine finished one word |
| tx_empty | output | 1 | Transmit side empty |
| tx_full | output | 1 | Transmit side full |
| rx_empty | output | 1 | Receive side empty |
| rx_full | output | 1 | Receive side full |
| tx_level_req | output | 1 | Transmit almost-empty request |
| rx_level_req | output | 1 | Receive almost-full request |
| irq_enable | input | 5 | Interrupt enable per status bit |
| irq_clear | input | 5 | Write-one-to-clear pulse per status bit |
| irq_status | output | 5 | Sticky event bits: 0 tx low, 1 underflow, 2 rx high, 3 overflow, 4 end of words |
| irq_out | output | 1 | Interrupt line |

## Verification
The hardest state to reach from the ports is a receive overflow. It needs the receive side completely full, slave mode selected and one more word pushed, and the same push in master mode must leave the overflow bit clear. The stimulus first fills the receive queue to capacity in master mode and pushes an extra word to show that nothing is flagged and that the extra word never appears on reads. It then drains the queue, refills it in slave mode and pushes again to see the bit set. Clearing a bit in the same cycle as a new underflow is forced the same way, by holding `eng_tx_req` and the clear pulse together on an empty transmit side.

// File: rtl/spi_word_buf_pkg.sv
// Package: shared constants and types for the SPI channel word buffer.
// Assumes: five event sources; the bit order is visible in irq_status.
package spi_word_buf_pkg;
    localparam int IRQW       = 5;
    localparam int IRQ_TX_LOW = 0;
    localparam int IRQ_TX_UND = 1;
    localparam int IRQ_RX_HIGH = 2;
    localparam int IRQ_RX_OVF = 3;
    localparam int IRQ_EOW    = 4;

    typedef logic [IRQW-1:0] irq_vec_t;
endpackage

// File: rtl/wbuf_queue.sv
// Module: wbuf_queue
// A first-word-fall-through word queue. With buf_en high it holds DEPTH words.
// With buf_en low it acts as one holding register.
// Assumes: a push to a full queue and a pop from an empty queue are dropped.
// Fullness is judged before a pop in the same cycle, so push and pop on a
// full queue accept only the pop.
module wbuf_queue #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          buf_en,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic [CW-1:0] cap;
    logic          push_ok, pop_ok;

    assign cap     = buf_en ? CW'(DEPTH) : CW'(1);
    assign empty   = (count == '0);
    assign full    = (count >= cap);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Pointer advance: a power-of-two depth wraps naturally, otherwise compare.
    generate
        if (DEPTH == (1 << PW)) begin : g_pow2
            assign wr_nxt = wr_ptr + PW'(1);
            assign rd_nxt = rd_ptr + PW'(1);
        end else begin : g_wrap
            assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
            assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
        end
    endgenerate

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_nxt;
            if (pop_ok)  rd_ptr <= rd_nxt;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/wbuf_word_counter.sv
// Module: wbuf_word_counter
// Counts finished words and pulses eow when the programmed total is reached.
// It then restarts from zero.
// Assumes: a total of zero disables counting and holds the count at zero.
module wbuf_word_counter #(
    parameter int CNTW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            word_done,
    input  logic [CNTW-1:0] word_total,
    output logic            eow
);
    logic [CNTW-1:0] done_cnt;
    logic [CNTW:0]   cnt_inc;
    logic            active;

    assign active  = (word_total != '0);
    assign cnt_inc = {1'b0, done_cnt} + (CNTW + 1)'(1);
    assign eow     = active && word_done && (cnt_inc >= {1'b0, word_total});

    // Running count of words in the current transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            done_cnt <= '0;
        end else if (word_done) begin
            done_cnt <= eow ? '0 : cnt_inc[CNTW-1:0];
        end
    end
endmodule

// File: rtl/wbuf_irq.sv
// Module: wbuf_irq
// Sticky event bits with write-one-to-clear and an enable-masked output.
// Assumes: an event in the same cycle as a clear wins.
module wbuf_irq
    import spi_word_buf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  irq_vec_t events,
    input  irq_vec_t clr,
    input  irq_vec_t en,
    output irq_vec_t status,
    output logic     irq
);
    // Hold events until cleared; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr) | events;
    end

    assign irq = |(status & en);
endmodule

// File: rtl/spi_word_buf.sv
// Module: spi_word_buf (top)
// Transmit and receive word queues for one SPI channel, with level requests,
// transfer word counting, and underflow and overflow detection feeding the
// interrupt status.
// Assumes: configuration inputs are static while words are in flight.
module spi_word_buf
    import spi_word_buf_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    parameter int LVLW  = 8,
    parameter int CNTW  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_queue_on,
    input  logic            rx_queue_on,
    input  logic            slave_mode,
    input  logic [LVLW-1:0] tx_low_mark,
    input  logic [LVLW-1:0] rx_high_mark,
    input  logic [CNTW-1:0] xfer_words,
    input  logic            host_wr_en,
    input  logic [DW-1:0]   host_wr_data,
    input  logic            host_rd_en,
    output logic [DW-1:0]   host_rd_data,
    input  logic            eng_tx_req,
    output logic [DW-1:0]   eng_tx_data,
    input  logic            eng_rx_push,
    input  logic [DW-1:0]   eng_rx_data,
    input  logic            eng_word_done,
    output logic            tx_empty,
    output logic            tx_full,
    output logic            rx_empty,
    output logic            rx_full,
    output logic            tx_level_req,
    output logic            rx_level_req,
    input  logic [IRQW-1:0] irq_enable,
    input  logic [IRQW-1:0] irq_clear,
    output logic [IRQW-1:0] irq_status,
    output logic            irq_out
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int MW = (CW > LVLW) ? CW : LVLW;

    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          eow;
    irq_vec_t      events;

    wbuf_queue #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .buf_en(tx_queue_on),
        .push(host_wr_en), .push_data(host_wr_data),
        .pop(eng_tx_req), .head(eng_tx_data),
        .empty(tx_empty), .full(tx_full), .count(tx_cnt)
    );

    wbuf_queue #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .buf_en(rx_queue_on),
        .push(eng_rx_push), .push_data(eng_rx_data),
        .pop(host_rd_en), .head(host_rd_data),
        .empty(rx_empty), .full(rx_full), .count(rx_cnt)
    );

    wbuf_word_counter #(.CNTW(CNTW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .word_done(eng_word_done),
        .word_total(xfer_words), .eow(eow)
    );

    // Level requests compare occupancy against the programmed marks.
    always_comb begin
        tx_level_req = (MW'(tx_cnt) <= MW'(tx_low_mark));
        rx_level_req = (MW'(rx_cnt) >= MW'(rx_high_mark));
    end

    // Gather event sources into their status bit positions.
    always_comb begin
        events              = '0;
        events[IRQ_TX_LOW]  = tx_level_req;
        events[IRQ_TX_UND]  = eng_tx_req && tx_empty;
        events[IRQ_RX_HIGH] = rx_level_req;
        events[IRQ_RX_OVF]  = eng_rx_push && rx_full && slave_mode;
        events[IRQ_EOW]     = eow;
    end

    wbuf_irq u_irq (
        .clk(clk), .rst_n(rst_n), .events(events), .clr(irq_clear),
        .en(irq_enable), .status(irq_status), .irq(irq_out)
    );
endmodule

// File: rtl/spi_word_buf_chk.sv
// Module: spi_word_buf_chk
// Port-level properties of spi_word_buf, attached with bind.
module spi_word_buf_chk #(
    parameter int DW   = 16,
    parameter int CNTW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tx_queue_on,
    input logic            slave_mode,
    input logic [CNTW-1:0] xfer_words,
    input logic            host_wr_en,
    input logic            eng_tx_req,
    input logic [DW-1:0]   eng_tx_data,
    input logic            eng_rx_push,
    input logic            tx_empty,
    input logic            tx_full,
    input logic            rx_full,
    input logic [4:0]      irq_clear,
    input logic [4:0]      irq_status
);
    a_r3_single_word_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_queue_on && !tx_empty) |-> tx_full);

    a_r4_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && host_wr_en && !eng_tx_req) |=> (tx_full && $stable(eng_tx_data)));

    a_r8_no_eow_when_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_words == '0 && !irq_status[4]) |=> !irq_status[4]);

    a_r9_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_req && tx_empty) |=> irq_status[1]);

    a_r10_no_overflow_master: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_full && !slave_mode && !irq_status[3]) |=> !irq_status[3]);

    a_r11_sticky_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status[1] && !irq_clear[1]) |=> irq_status[1]);
endmodule

bind spi_word_buf spi_word_buf_chk #(.DW(DW), .CNTW(CNTW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_queue_on(tx_queue_on), .slave_mode(slave_mode),
    .xfer_words(xfer_words), .host_wr_en(host_wr_en), .eng_tx_req(eng_tx_req),
    .eng_tx_data(eng_tx_data), .eng_rx_push(eng_rx_push), .tx_empty(tx_empty),
    .tx_full(tx_full), .rx_full(rx_full), .irq_clear(irq_clear), .irq_status(irq_status)
);

// File: tb/sim_spi_word_buf.sv
// Directed bench for spi_word_buf: one task per scenario, each checks itself.
module sim_spi_word_buf;
    localparam int DW = 16;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_queue_on = 1'b1, rx_queue_on = 1'b1, slave_mode = 1'b0;
    logic [7:0] tx_low_mark = 8'd2, rx_high_mark = 8'd3;
    logic [15:0] xfer_words = 16'd0;
    logic host_wr_en = 1'b0, host_rd_en = 1'b0;
    logic [DW-1:0] host_wr_data = '0, eng_rx_data = '0;
    logic eng_tx_req = 1'b0, eng_rx_push = 1'b0, eng_word_done = 1'b0;
    logic [4:0] irq_enable = '0, irq_clear = '0;
    logic [DW-1:0] host_rd_data, eng_tx_data;
    logic tx_empty, tx_full, rx_empty, rx_full, tx_level_req, rx_level_req, irq_out;
    logic [4:0] irq_status;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    spi_word_buf u0 (.*);

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [DW-1:0] d);
        host_wr_en = 1'b1; host_wr_data = d; cyc(); host_wr_en = 1'b0;
    endtask

    task automatic eng_push(input logic [DW-1:0] d);
        eng_rx_push = 1'b1; eng_rx_data = d; cyc(); eng_rx_push = 1'b0;
    endtask

    task automatic t_reset();
        chk({31'd0, tx_empty}, 1, "R1 tx_empty");
        chk({31'd0, tx_full}, 0, "R1 tx_full");
        chk({31'd0, rx_empty}, 1, "R1 rx_empty");
        chk({31'd0, rx_full}, 0, "R1 rx_full");
        chk({27'd0, irq_status}, 0, "R1 irq_status");
        chk({31'd0, irq_out}, 0, "R1 irq_out");
    endtask

    task automatic t_tx_queue();
        tx_queue_on = 1'b1; tx_low_mark = 8'd2;
        for (int i = 0; i < DEPTH; i++) begin
            host_write(16'hA0 + 16'(i));
            if (i == 1) chk({31'd0, tx_level_req}, 1, "R5 two held at mark 2");
            if (i == 2) chk({31'd0, tx_level_req}, 0, "R5 three held above mark");
        end
        chk({31'd0, tx_full}, 1, "R3 full at depth");
        host_write(16'hFFFF);
        chk({31'd0, tx_full}, 1, "R4 still full after extra write");
        for (int i = 0; i < DEPTH; i++) begin
            chk({16'd0, eng_tx_data}, 32'hA0 + 32'(i), "R2 tx order");
            eng_tx_req = 1'b1; cyc(); eng_tx_req = 1'b0;
        end
        chk({31'd0, tx_empty}, 1, "R4 extra write never stored");
    endtask

    task automatic t_tx_single();
        tx_queue_on = 1'b0;
        host_write(16'h1234);
        chk({31'd0, tx_full}, 1, "R3 single register full");
        host_write(16'h5678);
        chk({16'd0, eng_tx_data}, 32'h1234, "R3 holding register kept first word");
        eng_tx_req = 1'b1; cyc(); eng_tx_req = 1'b0;
        chk({31'd0, tx_empty}, 1, "R3 single register drained");
        tx_queue_on = 1'b1;
    endtask

    task automatic t_rx_queue();
        rx_queue_on = 1'b1; rx_high_mark = 8'd3; slave_mode = 1'b0;
        irq_clear = 5'b01000; cyc(); irq_clear = '0;
        for (int i = 0; i < DEPTH; i++) begin
            eng_push(16'hB0 + 16'(i));
            if (i == 1) chk({31'd0, rx_level_req}, 0, "R6 two held below mark");
            if (i == 2) chk({31'd0, rx_level_req}, 1, "R6 three held at mark");
        end
        chk({31'd0, rx_full}, 1, "R3 rx full at depth");
        eng_push(16'hEEEE);
        chk({28'd0, irq_status[3]}, 0, "R10 no overflow in master mode");
        for (int i = 0; i < DEPTH; i++) begin
            chk({16'd0, host_rd_data}, 32'hB0 + 32'(i), "R2 rx order");
            host_rd_en = 1'b1; cyc(); host_rd_en = 1'b0;
        end
        chk({31'd0, rx_empty}, 1, "R10 dropped word absent");
        host_rd_en = 1'b1; cyc(); host_rd_en = 1'b0;
        chk({31'd0, rx_empty}, 1, "R4 read of empty ignored");
        eng_push(16'h0055);
        chk({16'd0, host_rd_data}, 32'h55, "R4 order kept after empty read");
        chk({31'd0, rx_full}, 0, "R4 one word after empty read");
        host_rd_en = 1'b1; cyc(); host_rd_en = 1'b0;
        slave_mode = 1'b1;
        for (int i = 0; i < DEPTH; i++) eng_push(16'(i));
        eng_push(16'hDDDD);
        chk({31'd0, irq_status[3]}, 1, "R10 overflow in slave mode");
        slave_mode = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            host_rd_en = 1'b1; cyc(); host_rd_en = 1'b0;
        end
        chk({31'd0, rx_empty}, 1, "R10 rx drained");
    endtask

    task automatic t_underflow_irq();
        irq_clear = 5'b11111; cyc(); irq_clear = '0;
        chk({31'd0, irq_status[1]}, 0, "R11 clear by one");
        eng_tx_req = 1'b1; cyc(); eng_tx_req = 1'b0;
        chk({31'd0, irq_status[1]}, 1, "R9 underflow set");
        cyc(); cyc();
        chk({31'd0, irq_status[1]}, 1, "R11 bit sticky");
        irq_enable = 5'b00010; #1;
        chk({31'd0, irq_out}, 1, "R11 irq_out enabled");
        irq_enable = 5'b00000; #1;
        chk({31'd0, irq_out}, 0, "R11 irq_out masked");
        irq_enable = 5'b00001; #1;
        chk({31'd0, irq_out}, 1, "R11 tx low bit enabled");
        irq_enable = '0;
        eng_tx_req = 1'b1; irq_clear = 5'b00010; cyc();
        eng_tx_req = 1'b0; irq_clear = '0;
        chk({31'd0, irq_status[1]}, 1, "R11 set wins over clear");
        irq_clear = 5'b00010; cyc(); irq_clear = '0;
        chk({31'd0, irq_status[1]}, 0, "R11 cleared");
    endtask

    task automatic t_word_count();
        xfer_words = 16'd3;
        irq_clear = 5'b10000; cyc(); irq_clear = '0;
        for (int i = 0; i < 2; i++) begin
            eng_word_done = 1'b1; cyc(); eng_word_done = 1'b0;
        end
        chk({31'd0, irq_status[4]}, 0, "R7 no event before total");
        eng_word_done = 1'b1; cyc(); eng_word_done = 1'b0;
        chk({31'd0, irq_status[4]}, 1, "R7 event at total");
        irq_clear = 5'b10000; cyc(); irq_clear = '0;
        for (int i = 0; i < 2; i++) begin
            eng_word_done = 1'b1; cyc(); eng_word_done = 1'b0;
        end
        chk({31'd0, irq_status[4]}, 0, "R7 count restarted");
        eng_word_done = 1'b1; cyc(); eng_word_done = 1'b0;
        chk({31'd0, irq_status[4]}, 1, "R7 second transfer event");
        irq_clear = 5'b10000; xfer_words = 16'd0; cyc(); irq_clear = '0;
        for (int i = 0; i < 5; i++) begin
            eng_word_done = 1'b1; cyc(); eng_word_done = 1'b0;
        end
        chk({31'd0, irq_status[4]}, 0, "R8 zero total never fires");
    endtask

    initial begin
        #(8 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        cyc(); cyc();
        rst_n = 1'b1;
        #1;
        t_reset();
        t_tx_queue();
        t_tx_single();
        t_rx_queue();
        t_underflow_irq();
        t_word_count();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule